// File: doc/BRIEF.md
# Pixel Data-Enable Width Checker

This block sits on the pixel-clock side of a serial video link transmitter. It watches the data-enable strobe, measures how long each high run and each low run lasts, and measures the distance between successive rising edges. It raises sticky error flags when a run is shorter than the link framing allows, or when a width that must be even turns out odd.

The rules depend on two static mode inputs. In sync-free mode the strobe carries no timing rule, so nothing is ever flagged. In framed mode with the high-frequency option off, high and low runs must each last at least 2 clocks. In framed mode with the high-frequency option on, high and low runs must each last at least 4 clocks. In that case the high time and the rising-to-rising period must also both be even. Runs are measured with saturating counters, and a saturated count is taken as legal. A one-cycle clear pulse drops the flags and restarts edge qualification.

Top module: `de_timing_checker`

## Requirements
- R1: Framed mode, high-frequency off: a high run shorter than 2 clocks, ending at a falling edge, sets `err_short_high`.
- R2: Framed mode, high-frequency off: a low run shorter than 2 clocks, ending at a rising edge, sets `err_short_low`. Odd widths are legal in this mode.
- R3: Framed mode, high-frequency on: a high run shorter than 4 clocks sets `err_short_high`, and a low run shorter than 4 clocks sets `err_short_low`.
- R4: Framed mode, high-frequency on: an odd high run, or an odd rising-to-rising period, sets `err_odd_len`. Even widths of 4 or more raise no flag.
- R5: With `sync_free` = 1, no flag is ever set, whatever the strobe does.
- R6: Run and period counters stop at 2^CNT_W-1. A run or period that reaches this cap is legal and never raises `err_odd_len`, while a shorter odd run is still flagged.
- R7: The first checks after reset or a clear are qualified by earlier edges. A high run is checked only if its rising edge came after the reset or clear. A low run is checked only if its falling edge came after it. A period is checked only from the second rising edge after it.
- R8: Flags stay set until `clr`. A `clr` pulse zeroes all flags on the following clock, and it overrides a violation detected in the same cycle.
- R9: In a cycle where `sync_free` or `hf_mode` differs from its value in the previous cycle, the flags do not change.
- R10: A flag becomes visible right after the clock edge that samples the edge ending the offending run, and not earlier.
- R11: After reset all three flags are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| de | input | 1 | Pixel data-enable strobe under test |
| sync_free | input | 1 | 1 = sync-free mode (no rules), 0 = framed mode |
| hf_mode | input | 1 | 1 = high-frequency option on (min 4, even widths) |
| clr | input | 1 | One-cycle clear of flags and edge qualification |
| err_short_high | output | 1 | Sticky: high run below minimum |
| err_short_low | output | 1 | Sticky: low run below minimum |
| err_odd_len | output | 1 | Sticky: odd high run or odd period in high-frequency mode |

## Verification
The bench builds the checker with CNT_W = 6, so the counters cap at 63. Runs of 61, 62 and 101 clocks then bring the saturation boundary within reach in a short run. Within that configuration it sweeps every pairing of low and high widths from 1 to 8 in both framed variants and computes the expected flags from the width arithmetic. It also sweeps sync-free mode, and adds directed sequences for clear priority, mode-change suppression, first-edge qualification and the exact cycle a flag appears.

// File: rtl/de_timing_pkg.sv
`timescale 1ns/1ps
package de_timing_pkg;

    localparam int MIN_RUN_NORMAL = 2;
    localparam int MIN_RUN_HF     = 4;

    localparam int NUM_METERS   = 3;
    localparam int METER_HIGH   = 0;
    localparam int METER_LOW    = 1;
    localparam int METER_PERIOD = 2;

    typedef struct packed {
        logic short_high;
        logic short_low;
        logic odd_len;
    } de_viol_t;

    typedef struct packed {
        logic valid;
        logic de;
        logic sync_free;
        logic hf;
        logic seen_rise;
        logic seen_fall;
    } de_track_t;

endpackage

// File: rtl/de_run_meter.sv
`timescale 1ns/1ps
module de_run_meter #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         start,
    input  logic         adv,
    output logic [W-1:0] count
);
    localparam logic [W-1:0] CAP = '1;
    localparam logic [W-1:0] ONE = W'(1);

    logic [W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (start) begin
            cnt_d = ONE;
        end else if (adv && (cnt_q != CAP)) begin
            cnt_d = cnt_q + ONE;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign count = cnt_q;

    // R6: once at the cap, the count stays there until a new run starts
    assert_cap_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!start && cnt_q == CAP) |=> (cnt_q == CAP));

    // R6: a run always restarts from one
    assert_restart_one_R6: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> (cnt_q == ONE));

endmodule

// File: rtl/de_edge_tracker.sv
`timescale 1ns/1ps
module de_edge_tracker
    import de_timing_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic de,
    input  logic sync_free,
    input  logic hf_mode,
    input  logic clr,
    output logic rise,
    output logic fall,
    output logic mode_stable,
    output logic seen_rise,
    output logic seen_fall
);
    de_track_t trk_d, trk_q;

    always_comb begin
        rise        = trk_q.valid && de && !trk_q.de;
        fall        = trk_q.valid && !de && trk_q.de;
        mode_stable = trk_q.valid
                   && (trk_q.sync_free == sync_free)
                   && (trk_q.hf == hf_mode);

        trk_d           = trk_q;
        trk_d.valid     = 1'b1;
        trk_d.de        = de;
        trk_d.sync_free = sync_free;
        trk_d.hf        = hf_mode;
        if (clr) begin
            trk_d.seen_rise = 1'b0;
            trk_d.seen_fall = 1'b0;
        end else begin
            trk_d.seen_rise = trk_q.seen_rise | rise;
            trk_d.seen_fall = trk_q.seen_fall | fall;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            trk_q <= '0;
        end else begin
            trk_q <= trk_d;
        end
    end

    assign seen_rise = trk_q.seen_rise;
    assign seen_fall = trk_q.seen_fall;

endmodule

// File: rtl/de_rule_judge.sv
`timescale 1ns/1ps
module de_rule_judge
    import de_timing_pkg::*;
#(
    parameter int W = 16
) (
    input  logic         sync_free,
    input  logic         hf_mode,
    input  logic         mode_stable,
    input  logic         rise,
    input  logic         fall,
    input  logic         seen_rise,
    input  logic         seen_fall,
    input  logic [W-1:0] high_cnt,
    input  logic [W-1:0] low_cnt,
    input  logic [W-1:0] per_cnt,
    output de_viol_t     viol
);
    localparam logic [W-1:0] CAP     = '1;
    localparam logic [W-1:0] MIN_NRM = W'(MIN_RUN_NORMAL);
    localparam logic [W-1:0] MIN_HF  = W'(MIN_RUN_HF);

    logic [W-1:0] min_run;
    logic         armed;
    logic         high_done, low_done, per_done;

    always_comb begin
        min_run   = hf_mode ? MIN_HF : MIN_NRM;
        armed     = !sync_free && mode_stable;
        high_done = armed && fall && seen_rise;
        low_done  = armed && rise && seen_fall;
        per_done  = armed && rise && seen_rise;

        viol.short_high = high_done && (high_cnt < min_run);
        viol.short_low  = low_done  && (low_cnt  < min_run);
        viol.odd_len    = hf_mode && (
                              (high_done && high_cnt[0] && (high_cnt != CAP))
                           || (per_done  && per_cnt[0]  && (per_cnt  != CAP)));
    end

endmodule

// File: rtl/de_timing_checker.sv
`timescale 1ns/1ps
module de_timing_checker
    import de_timing_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic de,
    input  logic sync_free,
    input  logic hf_mode,
    input  logic clr,
    output logic err_short_high,
    output logic err_short_low,
    output logic err_odd_len
);
    logic rise, fall, mode_stable, seen_rise, seen_fall;

    de_edge_tracker u_track (
        .clk         (clk),
        .rst_n       (rst_n),
        .de          (de),
        .sync_free   (sync_free),
        .hf_mode     (hf_mode),
        .clr         (clr),
        .rise        (rise),
        .fall        (fall),
        .mode_stable (mode_stable),
        .seen_rise   (seen_rise),
        .seen_fall   (seen_fall)
    );

    logic [NUM_METERS-1:0] m_start, m_adv;
    logic [CNT_W-1:0]      m_cnt [NUM_METERS];

    always_comb begin
        m_start[METER_HIGH]   = rise;
        m_adv[METER_HIGH]     = de;
        m_start[METER_LOW]    = fall;
        m_adv[METER_LOW]      = !de;
        m_start[METER_PERIOD] = rise;
        m_adv[METER_PERIOD]   = 1'b1;
    end

    for (genvar g = 0; g < NUM_METERS; g++) begin : g_meter
        de_run_meter #(.W(CNT_W)) u_meter (
            .clk   (clk),
            .rst_n (rst_n),
            .start (m_start[g]),
            .adv   (m_adv[g]),
            .count (m_cnt[g])
        );
    end

    de_viol_t viol;

    de_rule_judge #(.W(CNT_W)) u_judge (
        .sync_free   (sync_free),
        .hf_mode     (hf_mode),
        .mode_stable (mode_stable),
        .rise        (rise),
        .fall        (fall),
        .seen_rise   (seen_rise),
        .seen_fall   (seen_fall),
        .high_cnt    (m_cnt[METER_HIGH]),
        .low_cnt     (m_cnt[METER_LOW]),
        .per_cnt     (m_cnt[METER_PERIOD]),
        .viol        (viol)
    );

    de_viol_t flag_d, flag_q;

    always_comb begin
        if (clr) begin
            flag_d = '0;
        end else begin
            flag_d = flag_q | viol;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            flag_q <= '0;
        end else begin
            flag_q <= flag_d;
        end
    end

    assign err_short_high = flag_q.short_high;
    assign err_short_low  = flag_q.short_low;
    assign err_odd_len    = flag_q.odd_len;

    logic [2:0] flag_vec;
    assign flag_vec = {err_short_high, err_short_low, err_odd_len};

    // R1: one-cycle high run in framed, normal-rate mode must be flagged
    assert_short_high_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (fall && seen_rise && mode_stable && !sync_free && !hf_mode && !clr
         && m_cnt[METER_HIGH] < CNT_W'(MIN_RUN_NORMAL)) |=> err_short_high);

    // R3: a low run under four clocks in high-frequency mode must be flagged
    assert_short_low_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (rise && seen_fall && mode_stable && !sync_free && hf_mode && !clr
         && m_cnt[METER_LOW] < CNT_W'(MIN_RUN_HF)) |=> err_short_low);

    // R5: sync-free mode never changes the flags except through clear
    assert_sync_free_quiet_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (sync_free && !clr) |=> $stable(flag_vec));

    // R8: flags never drop without a clear
    assert_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !clr |=> ((flag_vec | $past(flag_vec)) == flag_vec));

    // R8: clear zeroes all flags on the next clock
    assert_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (flag_vec == 3'b000));

    // R9: no flag update in a cycle where the mode inputs moved
    assert_mode_change_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (({sync_free, hf_mode} != $past({sync_free, hf_mode})) && !clr)
        |=> $stable(flag_vec));

endmodule

// File: tb/de_timing_checker_test.sv
`timescale 1ns/1ps
module de_timing_checker_test;

    localparam int CW = 6;

    logic clk = 1'b0;
    logic rst_n, de, sync_free, hf_mode, clr;
    logic err_short_high, err_short_low, err_odd_len;

    int n_run  = 0;
    int n_fail = 0;
    bit done   = 0;

    always #2.5 clk = ~clk;

    de_timing_checker #(.CNT_W(CW)) uut (
        .clk            (clk),
        .rst_n          (rst_n),
        .de             (de),
        .sync_free      (sync_free),
        .hf_mode        (hf_mode),
        .clr            (clr),
        .err_short_high (err_short_high),
        .err_short_low  (err_short_low),
        .err_odd_len    (err_odd_len)
    );

    task automatic seg(input logic v, input int n);
        de = v;
        repeat (n) @(negedge clk);
    endtask

    task automatic pulse_clr();
        clr = 1'b1;
        @(negedge clk);
        clr = 1'b0;
    endtask

    task automatic check(input logic [2:0] exp, input string tag);
        logic [2:0] got;
        got = {err_short_high, err_short_low, err_odd_len};
        n_run++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: flags {high,low,odd} got %b expected %b", tag, got, exp);
        end
    endtask

    // low L then high H between long legal runs; flags read after a closing low
    task automatic pattern(input int l, input int h);
        pulse_clr();
        seg(1'b0, 6);
        seg(1'b1, 6);
        seg(1'b0, l);
        seg(1'b1, h);
        seg(1'b0, 6);
        seg(1'b1, 6);
        seg(1'b0, 3);
    endtask

    task automatic set_mode(input logic sf, input logic hf);
        sync_free = sf;
        hf_mode   = hf;
        seg(1'b0, 2);
    endtask

    initial begin
        rst_n = 1'b0; de = 1'b0; sync_free = 1'b0; hf_mode = 1'b0; clr = 1'b0;
        repeat (4) @(negedge clk);
        check(3'b000, "R11 flags during reset");
        rst_n = 1'b1;
        seg(1'b0, 3);
        check(3'b000, "R11 flags after reset");

        // R1 R2 R3 R4: full width sweep in both framed variants
        for (int hf = 0; hf < 2; hf++) begin
            set_mode(1'b0, hf[0]);
            for (int l = 1; l <= 8; l++) begin
                for (int h = 1; h <= 8; h++) begin
                    int mn;
                    logic [2:0] exp;
                    mn = (hf == 1) ? 4 : 2;
                    exp[2] = (h < mn);
                    exp[1] = (l < mn);
                    exp[0] = (hf == 1) && (((h % 2) == 1) || ((l % 2) == 1));
                    pattern(l, h);
                    check(exp, $sformatf("%s hf=%0d L=%0d H=%0d",
                          (hf == 1) ? "R3/R4" : "R1/R2", hf, l, h));
                end
            end
        end

        // R5: sync-free mode ignores every width
        for (int hf = 0; hf < 2; hf++) begin
            set_mode(1'b1, hf[0]);
            for (int l = 1; l <= 5; l++) begin
                for (int h = 1; h <= 5; h++) begin
                    pattern(l, h);
                    check(3'b000, $sformatf("R5 sync-free hf=%0d L=%0d H=%0d", hf, l, h));
                end
            end
        end

        // R6: saturated runs and periods are legal, odd run below cap is not
        set_mode(1'b0, 1'b1);
        pulse_clr();
        seg(1'b0, 6); seg(1'b1, 6); seg(1'b0, 101); seg(1'b1, 101);
        seg(1'b0, 6); seg(1'b1, 6); seg(1'b0, 3);
        check(3'b000, "R6 runs of 101 past cap 63");
        pulse_clr();
        seg(1'b0, 6); seg(1'b1, 6); seg(1'b0, 6); seg(1'b1, 61); seg(1'b0, 4);
        check(3'b001, "R6 odd high of 61 below cap");
        pulse_clr();
        seg(1'b0, 6); seg(1'b1, 6); seg(1'b0, 6); seg(1'b1, 62);
        seg(1'b0, 6); seg(1'b1, 6); seg(1'b0, 3);
        check(3'b000, "R6 even high of 62");

        // R7: edge qualification after clear
        seg(1'b0, 6);
        de = 1'b1;
        pulse_clr();
        seg(1'b0, 4);
        seg(1'b1, 4);
        seg(1'b0, 5);
        check(3'b000, "R7 first high and first period unchecked");
        seg(1'b1, 4);
        check(3'b001, "R7 odd period at second rise");

        // R10: flag appears at the sampled edge, not before
        set_mode(1'b0, 1'b0);
        pulse_clr();
        seg(1'b0, 6); seg(1'b1, 6); seg(1'b0, 4); seg(1'b1, 1);
        check(3'b000, "R10 before falling edge");
        seg(1'b0, 1);
        check(3'b100, "R10 at falling edge");

        // R8: sticky, clear, clear priority
        pulse_clr();
        seg(1'b0, 6); seg(1'b1, 6); seg(1'b0, 1); seg(1'b1, 6); seg(1'b0, 20);
        check(3'b010, "R8 short low still held");
        pulse_clr();
        check(3'b000, "R8 clear drops flags");
        seg(1'b1, 6); seg(1'b0, 1);
        de = 1'b1;
        pulse_clr();
        check(3'b000, "R8 clear beats same-cycle violation");
        seg(1'b1, 5);

        // R9: mode change in the violating cycle suppresses the update
        set_mode(1'b0, 1'b0);
        pulse_clr();
        seg(1'b0, 6); seg(1'b1, 6); seg(1'b0, 6); seg(1'b1, 1);
        hf_mode = 1'b1;
        seg(1'b0, 1);
        check(3'b000, "R9 update held on mode change");
        seg(1'b0, 5); seg(1'b1, 1); seg(1'b0, 2);
        check(3'b101, "R9 checking resumes once mode is steady");

        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog: run did not complete, got timeout expected finish");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

endmodule